// File: doc/BRIEF.md
# Paged Half-Word Register Bridge

This bridge lets a host that can only issue 16-bit management register reads and writes reach a space of 32-bit registers. The management frames arrive already parsed: a 5-bit device address, a 5-bit register number, 16 bits of write data and a read/write flag. The bridge forwards complete 32-bit reads and writes to an internal register bus.

The internal word index is built from three parts. The top part comes from a page register, which the host loads by writing to a fixed device/register pair. The middle part comes from the low bits of a device address in a window of eight addresses. The bottom part comes from the upper bits of the register number. The lowest bit of the register number selects a half. An even number means bits 15:0 of the word and the next odd number means bits 31:16. A write of a high half is only held. The following low-half write commits all 32 bits in one bus transaction. A low-half read performs the bus read and keeps the upper 16 bits. The following high-half read returns those kept bits, so the two halves always come from the same bus read.

Requests use a valid/ready handshake. The bridge drops `req_ready` while a bus transaction or a read response is outstanding. The bus request is held until `bus_ready`. A read response is held until `rsp_ready`. Writes produce no response.

Top module: `mdio_paged_bridge`

## Requirements
- R1: After reset, req_ready is 1, bus_valid and rsp_valid are 0, and the page register reads as 0.
- R2: A write to device 0x1F register 0x10 loads the page from req_wdata[8:0]. A read of the same location returns the page zero-extended to 16 bits.
- R3: The bus word index is {page[8:0], dev[2:0], reg[4:1]} for devices 0x10 to 0x17.
- R4: A write to an odd register in the window only stores the high half and starts no bus transaction.
- R5: A write to an even register in the window starts exactly one bus write with data {stored high half, req_wdata}.
- R6: A read of an even register in the window starts exactly one bus read and returns bus_rdata[15:0].
- R7: A read of an odd register in the window starts no bus transaction. It returns bits 31:16 captured by the latest low-half read, even if the register content has changed since.
- R8: Writes to devices outside 0x10 to 0x17, and to other registers of device 0x1F, change nothing and start no bus transaction. Reads of these locations return 0xFFFF.
- R9: While a bus request is waiting for bus_ready, bus_valid, bus_addr, bus_wdata and bus_write stay stable and req_ready is 0. A read response stays valid and stable until rsp_ready, with req_ready at 0.
- R10: The stored high half persists. A second low-half write without a new high-half write reuses the previous high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Management request present |
| req_ready | output | 1 | Request accepted on this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device address of the request |
| req_reg | input | 5 | Register number of the request |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes the read data |
| rsp_rdata | output | 16 | Read data |
| bus_valid | output | 1 | Internal bus request |
| bus_ready | input | 1 | Internal bus completes the request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | 32-bit word index |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
The mapping is tried with pages 0, all ones and two mixed patterns, across the lowest, highest and middle window devices and register numbers. A swapped or shifted address field therefore lands on a different word index. The high and low data halves are chosen distinct and asymmetric, so a swapped half order shows up. The model bus returns different data for the high half after a low-half read, which separates a latched high half from a fresh read. Stalls on the bus side and the response side show whether the handshakes hold their data and block new requests.

// File: rtl/mrb_pkg.sv
`timescale 1ns/1ps
package mrb_pkg;
  typedef enum logic [1:0] {K_NONE, K_PAGE, K_LO, K_HI} kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RSP} state_t;
endpackage

// File: rtl/mrb_decode.sv
`timescale 1ns/1ps
module mrb_decode
  import mrb_pkg::*;
#(
  parameter logic [4:0] PAGE_DEV = 5'h1F,
  parameter logic [4:0] PAGE_REG = 5'h10,
  parameter logic [4:0] WIN_BASE = 5'h10,
  parameter int DEV_SEL_W = 3
) (
  input  logic [4:0] dev,
  input  logic [4:0] regno,
  output kind_t      kind
);
  logic in_win;
  assign in_win = (dev[4:DEV_SEL_W] == WIN_BASE[4:DEV_SEL_W]);

  always_comb begin
    if (dev == PAGE_DEV && regno == PAGE_REG) kind = K_PAGE;
    else if (in_win && regno[0])              kind = K_HI;
    else if (in_win)                          kind = K_LO;
    else                                      kind = K_NONE;
  end
endmodule

// File: rtl/mrb_page.sv
`timescale 1ns/1ps
module mrb_page #(
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    page <= '0;
    else if (load) page <= din;
  end

  // R2: a load is visible on the next cycle
  p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> page == $past(din));
endmodule

// File: rtl/mdio_paged_bridge.sv
`timescale 1ns/1ps
module mdio_paged_bridge
  import mrb_pkg::*;
#(
  parameter int PAGE_W    = 9,
  parameter int DEV_SEL_W = 3,
  parameter int REG_SEL_W = 4,
  parameter int HALF_W    = 16,
  parameter logic [4:0] PAGE_DEV = 5'h1F,
  parameter logic [4:0] PAGE_REG = 5'h10,
  parameter logic [4:0] WIN_BASE = 5'h10,
  localparam int IDX_W  = PAGE_W + DEV_SEL_W + REG_SEL_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_dev,
  input  logic [4:0]        req_reg,
  input  logic [HALF_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HALF_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [IDX_W-1:0]  bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata
);
  state_t            state;
  kind_t             kind;
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] hi_wr_q;
  logic [HALF_W-1:0] hi_rd_q;
  logic              accept;

  assign req_ready = (state == ST_IDLE);
  assign bus_valid = (state == ST_BUS);
  assign rsp_valid = (state == ST_RSP);
  assign accept    = req_valid && req_ready;

  mrb_decode #(
    .PAGE_DEV(PAGE_DEV), .PAGE_REG(PAGE_REG),
    .WIN_BASE(WIN_BASE), .DEV_SEL_W(DEV_SEL_W)
  ) u_dec (
    .dev(req_dev), .regno(req_reg), .kind(kind)
  );

  mrb_page #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n),
    .load(accept && req_write && kind == K_PAGE),
    .din(req_wdata[PAGE_W-1:0]),
    .page(page)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hi_wr_q   <= '0;
      hi_rd_q   <= '0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          case (kind)
            K_PAGE: if (!req_write) begin
              rsp_rdata <= {{(HALF_W-PAGE_W){1'b0}}, page};
              state     <= ST_RSP;
            end
            K_HI: if (req_write) hi_wr_q <= req_wdata;
                  else begin
                    rsp_rdata <= hi_rd_q;
                    state     <= ST_RSP;
                  end
            K_LO: begin
              bus_addr  <= {page, req_dev[DEV_SEL_W-1:0], req_reg[REG_SEL_W:1]};
              bus_write <= req_write;
              bus_wdata <= {hi_wr_q, req_wdata};
              state     <= ST_BUS;
            end
            default: if (!req_write) begin
              rsp_rdata <= '1;
              state     <= ST_RSP;
            end
          endcase
        end
        ST_BUS: if (bus_ready) begin
          if (bus_write) state <= ST_IDLE;
          else begin
            rsp_rdata <= bus_rdata[HALF_W-1:0];
            hi_rd_q   <= bus_rdata[WORD_W-1:HALF_W];
            state     <= ST_RSP;
          end
        end
        ST_RSP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: bus request held until taken
  p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                && $stable(bus_wdata) && $stable(bus_write));
  // R9: response held until taken
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R4: high-half write starts no bus transaction
  p_hi_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && kind == K_HI |=> !bus_valid);
  // R5: low-half write carries the low data
  p_lo_write_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && kind == K_LO |=> bus_valid && bus_write
                                && bus_wdata[HALF_W-1:0] == $past(req_wdata));
  // R7: high-half read answers without the bus
  p_hi_read_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write && kind == K_HI |=> rsp_valid && !bus_valid);
  // R8: unmapped read answers all ones
  p_unmapped_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write && kind == K_NONE |=> rsp_valid && rsp_rdata == '1);
endmodule

// File: tb/tb_mdio_paged_bridge.sv
`timescale 1ns/1ps
module tb_mdio_paged_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic        bus_write;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  logic [15:0] salt = 16'h0000;
  int          wait_cfg = 0;
  int          wait_cnt = 0;
  int          txn_cnt = 0;
  logic [15:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic        last_wr = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  mdio_paged_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // model register space: low half ~index, high half index ^ salt
  assign bus_rdata = {bus_addr ^ salt, ~bus_addr};

  always @(negedge clk) begin
    if (bus_valid) begin
      if (wait_cnt >= wait_cfg) bus_ready <= 1'b1;
      else begin bus_ready <= 1'b0; wait_cnt <= wait_cnt + 1; end
    end else begin
      bus_ready <= 1'b0; wait_cnt <= 0;
    end
  end

  always @(posedge clk) begin
    if (bus_valid && bus_ready) begin
      txn_cnt    <= txn_cnt + 1;
      last_addr  <= bus_addr;
      last_wdata <= bus_wdata;
      last_wr    <= bus_write;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [4:0] dv, input logic [4:0] rg,
                      input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dev = dv; req_reg = rg; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    q = '0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      q = rsp_rdata;
      while (!rsp_ready) @(negedge clk);
      @(posedge clk);
    end else begin
      while (!req_ready) @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [8:0]  page;
    logic [4:0]  dev;
    logic [4:0]  rg;
    logic [15:0] lo;
    logic [15:0] hi;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{9'h000, 5'h10, 5'h00, 16'h1234, 16'hABCD},
    '{9'h1FF, 5'h17, 5'h1E, 16'hFFFF, 16'h0001},
    '{9'h0A5, 5'h13, 5'h0A, 16'h0000, 16'h8000},
    '{9'h15A, 5'h14, 5'h16, 16'h5A5A, 16'hC3C3}
  };

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [15:0] ea;
    int c0;
    int seen;
    logic [15:0] held;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 1);
    chk(bus_valid == 1'b0, "R1 bus_valid", {31'b0, bus_valid}, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 0);
    xfer(1'b0, 5'h1F, 5'h10, 16'h0, q);
    chk(q == 16'h0000, "R1 page after reset", {16'b0, q}, 0);

    // table walk: mapping, halves, ordering
    foreach (VEC[i]) begin
      xfer(1'b1, 5'h1F, 5'h10, {7'h7F, VEC[i].page}, q);
      xfer(1'b0, 5'h1F, 5'h10, 16'h0, q);
      chk(q == {7'b0, VEC[i].page}, "R2 page readback", {16'b0, q}, {23'b0, VEC[i].page});
      ea = {VEC[i].page, VEC[i].dev[2:0], VEC[i].rg[4:1]};
      c0 = txn_cnt;
      xfer(1'b1, VEC[i].dev, VEC[i].rg | 5'h01, VEC[i].hi, q);
      chk(txn_cnt == c0, "R4 high write no bus", txn_cnt, c0);
      xfer(1'b1, VEC[i].dev, VEC[i].rg, VEC[i].lo, q);
      chk(txn_cnt == c0 + 1 && last_wr, "R5 one bus write", txn_cnt, c0 + 1);
      chk(last_addr == ea, "R3 word index", {16'b0, last_addr}, {16'b0, ea});
      chk(last_wdata == {VEC[i].hi, VEC[i].lo}, "R5 write data", last_wdata, {VEC[i].hi, VEC[i].lo});
      xfer(1'b0, VEC[i].dev, VEC[i].rg, 16'h0, q);
      chk(txn_cnt == c0 + 2 && !last_wr && last_addr == ea, "R6 one bus read", txn_cnt, c0 + 2);
      chk(q == ~ea, "R6 low half", {16'b0, q}, {16'b0, ~ea});
      xfer(1'b0, VEC[i].dev, VEC[i].rg | 5'h01, 16'h0, q);
      chk(q == (ea ^ salt), "R7 high half", {16'b0, q}, {16'b0, ea ^ salt});
      chk(txn_cnt == c0 + 2, "R7 no bus on high read", txn_cnt, c0 + 2);
    end

    // R10: high half reused (page now 0x15A, last hi 0xC3C3)
    xfer(1'b1, 5'h11, 5'h02, 16'h7777, q);
    chk(last_wdata == 32'hC3C3_7777, "R10 high half persists", last_wdata, 32'hC3C3_7777);

    // R7: consistency after content change
    xfer(1'b1, 5'h1F, 5'h10, 16'h0003, q);
    salt = 16'h0000;
    xfer(1'b0, 5'h12, 5'h04, 16'h0, q);
    ea = {9'h003, 3'd2, 4'd2};
    salt = 16'hFFFF;
    xfer(1'b0, 5'h12, 5'h05, 16'h0, q);
    chk(q == ea, "R7 latched high after change", {16'b0, q}, {16'b0, ea});
    salt = 16'h0000;

    // R8: unmapped accesses
    c0 = txn_cnt;
    xfer(1'b1, 5'h05, 5'h00, 16'h1111, q);
    xfer(1'b1, 5'h1F, 5'h11, 16'h01FF, q);
    xfer(1'b1, 5'h18, 5'h02, 16'h2222, q);
    chk(txn_cnt == c0, "R8 unmapped write no bus", txn_cnt, c0);
    xfer(1'b0, 5'h1F, 5'h10, 16'h0, q);
    chk(q == 16'h0003, "R8 page unchanged", {16'b0, q}, 32'h3);
    xfer(1'b0, 5'h05, 5'h00, 16'h0, q);
    chk(q == 16'hFFFF, "R8 unmapped read", {16'b0, q}, 32'hFFFF);
    xfer(1'b0, 5'h1F, 5'h03, 16'h0, q);
    chk(q == 16'hFFFF, "R8 other page-device reg", {16'b0, q}, 32'hFFFF);
    xfer(1'b1, 5'h10, 5'h01, 16'h4444, q);
    xfer(1'b1, 5'h0F, 5'h01, 16'h9999, q);
    xfer(1'b1, 5'h10, 5'h00, 16'h0000, q);
    chk(last_wdata == 32'h4444_0000, "R8 unmapped odd write ignored", last_wdata, 32'h4444_0000);

    // R9: bus stall
    wait_cfg = 3;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_dev = 5'h16; req_reg = 5'h08; req_wdata = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    while (bus_valid && seen < 20) begin
      seen++;
      if (req_ready) chk(1'b0, "R9 req_ready low during bus", 1, 0);
      @(negedge clk);
    end
    chk(seen == 4, "R9 bus held until ready", seen, 4);
    chk(last_wdata == 32'h4444_BEEF, "R9 data after stall", last_wdata, 32'h4444_BEEF);
    wait_cfg = 0;

    // R9: response stall
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_dev = 5'h16; req_reg = 5'h08;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held && !req_ready, "R9 response held",
          {15'b0, rsp_valid, rsp_rdata}, {16'h0001, held});
    end
    ea = {9'h003, 3'd6, 4'd4};
    chk(held == ~ea, "R9 stalled read data", {16'b0, held}, {16'b0, ~ea});
    rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 release", {30'b0, rsp_valid, req_ready}, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule